// File: doc/BRIEF.md
# Multi-Scheme Overcurrent Trip Element

This block is a single-phase digital overcurrent protection element. On every sample strobe it takes one fixed-point RMS current magnitude, already referred to the secondary side, and compares it with a pickup setting. It then runs one of three trip characteristics, chosen by a scheme select input. The instantaneous scheme trips on the first sample above pickup. The definite-time scheme trips once pickup has held for a set number of power cycles. The inverse-time scheme uses a very-inverse curve, so a larger multiple of pickup gives a faster trip.

The curve is evaluated without a divider. The elapsed-time condition is cross-multiplied into integer products of the squared current, the squared pickup setting and the time dial. The trip output then holds for a fixed number of sample ticks and clears by itself. For a three-phase element, instantiate three copies and OR their trip outputs. An upstream backup element is graded above a downstream primary element by giving it a larger time dial.

Top module: `ocp_trip_element`

## Requirements
- R1: On each sample strobe the pickup output is registered as (i_mag > pickup_set). Equality does not pick up. Current and setting are both unsigned Q8.8 amperes.
- R2: With scheme = 0 (instantaneous), trip rises at the strobe edge of the first sample that picks up.
- R3: With scheme = 1 (definite-time), trip rises on the N-th consecutive picked-up sample, where N = dt_cycles × 128 samples per cycle. A setting of N = 0 trips on the first picked-up sample.
- R4: With scheme = 2 (inverse-time), trip rises on the first consecutive picked-up sample n at which n·D·256 ≥ TD·(11833·D + 476774·P²). Here D = I² − P², I is i_mag, P is pickup_set and TD is the raw time_dial (Q4.4). This is the curve TD·(0.0963 + 3.88/(M²−1)) seconds at 7680 samples per second.
- R5: A sample that does not pick up clears the elapsed sample count, so the definite-time and inverse-time delays start again from zero.
- R6: Once raised, trip stays high for exactly HOLD_TICKS strobes and then falls, whatever the current does. Picked-up samples during the hold neither extend it nor count toward a new delay. Counting starts again on the first strobe after release.
- R7: With scheme = 3 (off), trip never rises, but pickup still follows R1.
- R8: When sample_stb is low, pickup and trip do not change.
- R9: While rst_n is low, pickup and trip are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a new current sample |
| i_mag | input | IW | RMS current magnitude, secondary amperes, Q8.8 |
| pickup_set | input | IW | Pickup threshold, Q8.8 |
| scheme | input | 2 | 0 instantaneous, 1 definite-time, 2 inverse-time, 3 off |
| dt_cycles | input | CW | Definite-time delay in power cycles |
| time_dial | input | TDW | Inverse-time dial, Q4.4 |
| pickup | output | 1 | Current above pickup at the last sample |
| trip | output | 1 | Trip command, self-clearing after the hold |

## Verification
Two events can land on the same strobe edge, and the bench provokes both. In the first, trip rises in the same cycle that pickup first rises. The instantaneous scheme does this on every first fault sample, so the bench checks both flags after that single strobe. In the second, the hold expires while the fault is still present. The bench keeps a fault current applied throughout the hold and counts the strobes until trip falls. It then checks that the next picked-up sample starts a fresh delay: an immediate re-trip for the instantaneous scheme, and a full 128 samples for a one-cycle definite delay. The inverse-time trip sample is predicted in the bench from the integer curve inequality for several current, pickup and dial combinations.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    SCH_INST = 2'b00,
    SCH_DEFT = 2'b01,
    SCH_INVT = 2'b10,
    SCH_OFF  = 2'b11
  } scheme_e;

  // Curve constants in samples at 7680 Hz, scaled by 16 (dial Q4.4 adds 16 more)
  localparam longint unsigned IDMT_K_FIXED = 64'd11833;   // 0.0963 s
  localparam longint unsigned IDMT_K_INV   = 64'd476774;  // 3.88 s
  localparam int              IDMT_SCALE_LG = 8;          // 16 x 16

endpackage

// File: rtl/ocp_pickup_cmp.sv
module ocp_pickup_cmp #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [IW-1:0] cur,
  input  logic [IW-1:0] thr,
  output logic          above,
  output logic          pickup_q
);

  logic pickup_d;

  assign above = (cur > thr);

  always_comb begin
    pickup_d = pickup_q;
    if (stb) pickup_d = above;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pickup_q <= 1'b0;
    else        pickup_q <= pickup_d;
  end

endmodule

// File: rtl/ocp_elapsed_ctr.sv
module ocp_elapsed_ctr #(
  parameter int ETW = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb,
  input  logic           above,
  input  logic           hold_clr,
  output logic [ETW-1:0] n_now
);

  localparam logic [ETW-1:0] CNT_MAX = {ETW{1'b1}};

  logic [ETW-1:0] cnt_q;
  logic [ETW-1:0] cnt_d;

  always_comb begin
    if (!above)               n_now = '0;
    else if (cnt_q == CNT_MAX) n_now = CNT_MAX;
    else                      n_now = cnt_q + 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (stb) cnt_d = hold_clr ? '0 : n_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ocp_idmt_cmp.sv
module ocp_idmt_cmp
  import ocp_pkg::*;
#(
  parameter int IW  = 16,
  parameter int TDW = 8,
  parameter int ETW = 20
) (
  input  logic [IW-1:0]  cur,
  input  logic [IW-1:0]  thr,
  input  logic [TDW-1:0] dial,
  input  logic [ETW-1:0] n_elapsed,
  output logic           reached
);

  localparam int LW = ETW + 2*IW + IDMT_SCALE_LG + 1;
  localparam int RW = TDW + 2*IW + 21;
  localparam int PW = (LW > RW) ? LW : RW;

  logic [PW-1:0] cur_sq, thr_sq, excess;
  logic [PW-1:0] lhs, rhs;

  always_comb begin
    cur_sq  = PW'(cur) * PW'(cur);
    thr_sq  = PW'(thr) * PW'(thr);
    excess  = cur_sq - thr_sq;
    lhs     = (PW'(n_elapsed) * excess) << IDMT_SCALE_LG;
    rhs     = PW'(dial) * ((PW'(IDMT_K_FIXED) * excess) + (PW'(IDMT_K_INV) * thr_sq));
    reached = (lhs >= rhs);
  end

endmodule

// File: rtl/ocp_trip_hold.sv
module ocp_trip_hold #(
  parameter int HOLD_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic fire,
  output logic trip_q
);

  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TICKS);

  logic          trip_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    trip_d = trip_q;
    hold_d = hold_q;
    if (stb) begin
      if (trip_q) begin
        if (hold_q <= HW'(1)) begin
          trip_d = 1'b0;
          hold_d = '0;
        end else begin
          hold_d = hold_q - 1'b1;
        end
      end else if (fire) begin
        trip_d = 1'b1;
        hold_d = HOLD_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      hold_q <= '0;
    end else begin
      trip_q <= trip_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/ocp_trip_element.sv
module ocp_trip_element
  import ocp_pkg::*;
#(
  parameter int IW         = 16,
  parameter int TDW        = 8,
  parameter int CW         = 8,
  parameter int SPC        = 128,
  parameter int ETW        = 20,
  parameter int HOLD_TICKS = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_stb,
  input  logic [IW-1:0]  i_mag,
  input  logic [IW-1:0]  pickup_set,
  input  logic [1:0]     scheme,
  input  logic [CW-1:0]  dt_cycles,
  input  logic [TDW-1:0] time_dial,
  output logic           pickup,
  output logic           trip
);

  localparam int SPC_LG = $clog2(SPC);
  localparam int TW     = CW + SPC_LG + 1;
  localparam int CMPW   = (ETW > TW) ? ETW : TW;

  scheme_e        mode;
  logic           above;
  logic [ETW-1:0] n_now;
  logic [TW-1:0]  dt_thr;
  logic           dt_reached;
  logic           inv_reached;
  logic           fire;

  assign mode = scheme_e'(scheme);

  ocp_pickup_cmp #(.IW(IW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (sample_stb),
    .cur      (i_mag),
    .thr      (pickup_set),
    .above    (above),
    .pickup_q (pickup)
  );

  ocp_elapsed_ctr #(.ETW(ETW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (sample_stb),
    .above    (above),
    .hold_clr (trip),
    .n_now    (n_now)
  );

  generate
    if ((1 << SPC_LG) == SPC) begin : gen_dt_shift
      assign dt_thr = TW'(dt_cycles) << SPC_LG;
    end else begin : gen_dt_mul
      assign dt_thr = TW'(dt_cycles) * TW'(SPC);
    end
  endgenerate

  assign dt_reached = (CMPW'(n_now) >= CMPW'(dt_thr));

  ocp_idmt_cmp #(.IW(IW), .TDW(TDW), .ETW(ETW)) u_idmt (
    .cur       (i_mag),
    .thr       (pickup_set),
    .dial      (time_dial),
    .n_elapsed (n_now),
    .reached   (inv_reached)
  );

  always_comb begin
    case (mode)
      SCH_INST: fire = above;
      SCH_DEFT: fire = above & dt_reached;
      SCH_INVT: fire = above & inv_reached;
      default:  fire = 1'b0;
    endcase
  end

  ocp_trip_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (sample_stb),
    .fire   (fire),
    .trip_q (trip)
  );

endmodule

// File: rtl/ocp_trip_checker.sv
module ocp_trip_checker #(
  parameter int IW         = 16,
  parameter int HOLD_TICKS = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_stb,
  input logic [IW-1:0] i_mag,
  input logic [IW-1:0] pickup_set,
  input logic [1:0]    scheme,
  input logic          pickup,
  input logic          trip
);

  logic [31:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held_q <= '0;
    else if (!trip)      held_q <= '0;
    else if (sample_stb) held_q <= held_q + 32'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!pickup && !trip)
        else $error("outputs active during reset");
    end
  end

  assert_quiet_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> ($stable(pickup) && $stable(trip)));

  assert_inst_first_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && scheme == 2'b00 && i_mag > pickup_set && !trip) |=> trip);

  assert_trip_with_pickup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> pickup);

  assert_dropout_no_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !(i_mag > pickup_set) && !trip) |=> !trip);

  assert_off_never_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && scheme == 2'b11 && !trip) |=> !trip);

  assert_hold_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (held_q < 32'(HOLD_TICKS)));

  assert_hold_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip) |-> (held_q == 32'(HOLD_TICKS)));

endmodule

bind ocp_trip_element ocp_trip_checker #(.IW(IW), .HOLD_TICKS(HOLD_TICKS)) u_trip_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .i_mag      (i_mag),
  .pickup_set (pickup_set),
  .scheme     (scheme),
  .pickup     (pickup),
  .trip       (trip)
);

// File: tb/test_ocp_trip_element.sv
`timescale 1ns/1ps
module test_ocp_trip_element;

  localparam int HOLD = 32;

  logic        clk;
  logic        rst_n;
  logic        sample_stb;
  logic [15:0] i_mag;
  logic [15:0] pickup_set;
  logic [1:0]  scheme;
  logic [7:0]  dt_cycles;
  logic [7:0]  time_dial;
  logic        pickup;
  logic        trip;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ocp_trip_element #(.HOLD_TICKS(HOLD)) i_ocp_trip_element (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .i_mag      (i_mag),
    .pickup_set (pickup_set),
    .scheme     (scheme),
    .dt_cycles  (dt_cycles),
    .time_dial  (time_dial),
    .pickup     (pickup),
    .trip       (trip)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic smp(input logic [15:0] cur);
    @(negedge clk);
    sample_stb = 1'b1;
    i_mag      = cur;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < HOLD + 2; k++) smp(16'd0);
  endtask

  // Applies cur until trip rises; returns sample index (1-based) or 0
  task automatic run_until(input logic [15:0] cur, input int limit, output int first);
    first = 0;
    for (int k = 1; k <= limit; k++) begin
      smp(cur);
      if (trip && first == 0) begin
        first = k;
        break;
      end
    end
  endtask

  task automatic hold_len(input logic [15:0] cur, output int n);
    n = 0;
    while (trip && n < 4 * HOLD) begin
      smp(cur);
      n++;
    end
  endtask

  function automatic longint idmt_expect(input longint i, input longint p, input longint td);
    longint d, rhs, den, n;
    d   = i * i - p * p;
    rhs = td * (11833 * d + 476774 * p * p);
    den = d * 256;
    n   = (rhs + den - 1) / den;
    return (n < 1) ? 1 : n;
  endfunction

  task automatic inv_case(input logic [15:0] i, input logic [15:0] p, input logic [7:0] td,
                          output int got);
    longint e;
    scheme     = 2'd2;
    pickup_set = p;
    time_dial  = td;
    settle();
    e = idmt_expect(longint'(i), longint'(p), longint'(td));
    run_until(i, int'(e) + 4, got);
    check("R4 inverse-time trip sample", got, e);
  endtask

  initial begin
    int first, n, t_fast, t_slow;
    bit any_trip;
    rst_n      = 1'b0;
    sample_stb = 1'b0;
    i_mag      = '0;
    pickup_set = 16'd256;
    scheme     = 2'd3;
    dt_cycles  = 8'd0;
    time_dial  = 8'd16;
    repeat (3) @(negedge clk);
    check("R9 pickup in reset", pickup, 0);
    check("R9 trip in reset", trip, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R7: sweep current around two thresholds with trip off
    any_trip = 0;
    for (int v = 0; v <= 600; v++) begin
      smp(16'(v));
      check("R1 pickup sweep", pickup, (v > 256) ? 1 : 0);
      if (trip) any_trip = 1;
    end
    pickup_set = 16'd1000;
    for (int v = 990; v <= 1010; v++) begin
      smp(16'(v));
      check("R1 pickup near 1000", pickup, (v > 1000) ? 1 : 0);
      if (trip) any_trip = 1;
    end
    check("R7 off scheme never trips", any_trip, 0);

    // R8: no strobe, nothing moves
    scheme     = 2'd0;
    pickup_set = 16'd256;
    smp(16'd0);
    @(negedge clk);
    i_mag = 16'd2000;
    repeat (6) @(negedge clk);
    check("R8 pickup held without strobe", pickup, 0);
    check("R8 trip held without strobe", trip, 0);

    // R2: instantaneous, trip and pickup on the same strobe
    smp(16'd2000);
    check("R2 instantaneous pickup", pickup, 1);
    check("R2 instantaneous trip", trip, 1);

    // R6: hold length with fault held, then immediate re-trip
    hold_len(16'd2000, n);
    check("R6 hold length", n, HOLD);
    smp(16'd2000);
    check("R6 re-trip after release", trip, 1);
    settle();
    run_until(16'd257, 3, first);
    check("R2 trip just above pickup", first, 1);
    settle();
    run_until(16'd256, 3, first);
    check("R2 no trip at pickup", first, 0);

    // R3: definite delay sweep
    scheme = 2'd1;
    for (int c = 0; c <= 4; c++) begin
      if (c == 3) continue;
      dt_cycles = 8'(c);
      settle();
      run_until(16'd1770, c * 128 + 4, first);
      check("R3 definite trip sample", first, (c == 0) ? 1 : c * 128);
    end

    // R5: dropout restarts the definite timer
    dt_cycles = 8'd1;
    settle();
    for (int k = 0; k < 100; k++) smp(16'd1770);
    check("R5 no trip before dropout", trip, 0);
    smp(16'd100);
    run_until(16'd1770, 200, first);
    check("R5 restart after dropout", first, 128);

    // R6: definite delay counts afresh after the hold
    hold_len(16'd1770, n);
    check("R6 hold with definite", n, HOLD);
    run_until(16'd1770, 200, first);
    check("R6 delay restarts after hold", first, 128);

    // R4: inverse-time curve cases
    inv_case(16'd3776, 16'd256, 8'd16, t_fast);
    inv_case(16'd3776, 16'd256, 8'd56, t_slow);
    check("R4 larger dial trips later", (t_slow > t_fast) ? 1 : 0, 1);
    inv_case(16'd512,  16'd256, 8'd16, first);
    inv_case(16'd300,  16'd256, 8'd1,  first);
    inv_case(16'd3752, 16'd128, 8'd16, first);

    // R5: dropout restarts the inverse timer
    scheme     = 2'd2;
    pickup_set = 16'd256;
    time_dial  = 8'd16;
    settle();
    for (int k = 0; k < 600; k++) smp(16'd3776);
    smp(16'd0);
    run_until(16'd3776, 1000, first);
    check("R5 inverse restart after dropout", first, idmt_expect(3776, 256, 16));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule